// File: doc/BRIEF.md
# I2C Interrupt Status Flag Unit

This block keeps three status flags for an I2C peripheral: a flag for a match on the second slave address, a flag for a continuous-transfer interrupt, and a general interrupt flag. The bus engine drives single-cycle event strobes into it. These strobes report a start condition, a finished address frame together with its 7-bit address, the transmit buffer becoming empty and the receive buffer becoming full. The block also takes the current mode (master or slave), the format-select bit and the programmed second address.

Software reaches the flags through one 8-bit register. The register has a read strobe, a write strobe and combinational read data. A flag can only be cleared by a two-step handshake: software first reads the flag as 1, then writes 0 to it. The hardware also clears some flags by itself. The interrupt request output is the general flag gated by a software enable bit.

Register layout:
- bit 0: general interrupt flag
- bit 1: continuous-transfer flag
- bit 2: second-address match flag
- bit 7: interrupt enable (read/write)
- bits 6..3: read as 0

Top module: `i2c_status_flags`

## Requirements
- R1: The match flag (bit 2) goes to 1 on the clock edge that samples addrDone, but only when all of these hold: the frame is the first address frame since the last startDet, isMaster=0, fmtSel=0, and addrByte equals secondAddr. Otherwise it does not set.
- R2: The match flag goes to 0 on an edge that samples startDet, and on any edge that samples isMaster=1.
- R3: A software write of 0 clears a flag only if that flag was read as 1 by a cpuRd cycle after the last write. A write of 0 without such a read leaves the flag unchanged.
- R4: In slave mode (isMaster=0), the continuous-transfer flag (bit 1) sets on a txEmptySet or rxFullSet edge only while the match flag is 1.
- R5: With isMaster=1, a txEmptySet or rxFullSet edge sets the continuous-transfer flag.
- R6: On the edge that sets the continuous-transfer flag, the general flag (bit 0) also sets.
- R7: A software clear of the general flag also clears the continuous-transfer flag on the same edge.
- R8: After reset, all flags and the enable bit read as 0 and irq is 0.
- R9: When a set event and a software clear hit the same flag on the same edge, the flag ends at 1.
- R10: Any register write cancels every earlier read, so a later write of 0 clears nothing until the flag is read as 1 again.
- R11: irq equals the general flag AND the enable bit. The enable bit is bit 7 and takes the value of bit 7 on every write.
- R12: Writing 1 to bits 0..2 never sets a flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| startDet | input | 1 | Start condition detected (strobe) |
| addrDone | input | 1 | Address frame complete (strobe) |
| addrByte | input | 7 | Address received in the frame |
| txEmptySet | input | 1 | Transmit buffer became empty (strobe) |
| rxFullSet | input | 1 | Receive buffer became full (strobe) |
| isMaster | input | 1 | 1 = master mode, 0 = slave mode |
| fmtSel | input | 1 | Format select; 0 enables second-address matching |
| secondAddr | input | 7 | Programmed second slave address |
| cpuRd | input | 1 | Register read strobe |
| cpuWr | input | 1 | Register write strobe |
| cpuWdata | input | 8 | Register write data |
| cpuRdata | output | 8 | Register read data |
| irq | output | 1 | Interrupt request |

## Verification
Suppose the handshake latch were wrong, for example stuck armed or not cleared by a write. The first unarmed write of 0 would then clear a flag it should not. That error shows on cpuRdata one cycle after the write. A stale first-frame tracker shows up one cycle after the next addrDone, as a match bit that should or should not be there. Every output bit is compared with a behavioural model on every cycle, so a divergence in any flag is reported in the cycle after the edge that caused it.

// File: rtl/i2cflag_pkg.sv
package i2cflag_pkg;
  localparam int REG_W    = 8;
  localparam int ADDR_W   = 7;
  localparam int GEN_BIT  = 0;
  localparam int XFER_BIT = 1;
  localparam int AAS_BIT  = 2;
  localparam int EN_BIT   = 7;
  localparam int NFLAGS   = 3;

  typedef struct packed {
    logic clrGen;
    logic clrXfer;
    logic clrAas;
    logic enWr;
    logic enVal;
  } flagCtl_t;
endpackage

// File: rtl/i2cflag_ctl.sv
module i2cflag_ctl
  import i2cflag_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpuRd,
  input  logic              cpuWr,
  input  logic [REG_W-1:0]  cpuWdata,
  input  logic [NFLAGS-1:0] flagsNow,
  output flagCtl_t          ctl
);
  localparam int FLAG_POS [NFLAGS] = '{GEN_BIT, XFER_BIT, AAS_BIT};

  logic [NFLAGS-1:0] armed;
  logic [NFLAGS-1:0] clrReq;

  // one observed-as-1 latch per flag
  for (genvar g = 0; g < NFLAGS; g++) begin : gArm
    always_ff @(posedge clk) begin
      if (!rst_n)     armed[g] <= 1'b0;
      else if (cpuWr) armed[g] <= 1'b0;
      else if (cpuRd && flagsNow[g]) armed[g] <= 1'b1;
    end
    assign clrReq[g] = cpuWr && armed[g] && !cpuWdata[FLAG_POS[g]];
  end

  always_comb begin
    ctl.clrGen  = clrReq[0];
    ctl.clrXfer = clrReq[1];
    ctl.clrAas  = clrReq[2];
    ctl.enWr    = cpuWr;
    ctl.enVal   = cpuWdata[EN_BIT];
  end

  // a clear strobe needs a read of that flag as 1 at some earlier cycle
  assert_clear_after_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.clrGen |-> armed[0] && $past(!cpuWr || cpuRd));
  assert_write_disarms_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cpuWr && !cpuRd) |=> !(ctl.clrGen || ctl.clrXfer || ctl.clrAas));
endmodule

// File: rtl/i2cflag_dp.sv
module i2cflag_dp
  import i2cflag_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              startDet,
  input  logic              addrDone,
  input  logic [ADDR_W-1:0] addrByte,
  input  logic              txEmptySet,
  input  logic              rxFullSet,
  input  logic              isMaster,
  input  logic              fmtSel,
  input  logic [ADDR_W-1:0] secondAddr,
  input  flagCtl_t          ctl,
  output logic              genFlag,
  output logic              xferFlag,
  output logic              aasFlag,
  output logic              irqEn
);
  logic firstPending;
  logic aasSet;
  logic xferSet;

  always_ff @(posedge clk) begin
    if (!rst_n)        firstPending <= 1'b0;
    else if (startDet) firstPending <= 1'b1;
    else if (addrDone) firstPending <= 1'b0;
  end

  assign aasSet  = addrDone && firstPending && !isMaster && !fmtSel
                   && (addrByte == secondAddr);
  assign xferSet = (txEmptySet || rxFullSet) && (isMaster || aasFlag);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      aasFlag  <= 1'b0;
      xferFlag <= 1'b0;
      genFlag  <= 1'b0;
      irqEn    <= 1'b0;
    end else begin
      if (aasSet) aasFlag <= 1'b1;
      else if (startDet || isMaster || ctl.clrAas) aasFlag <= 1'b0;

      if (xferSet) xferFlag <= 1'b1;
      else if (ctl.clrXfer || ctl.clrGen) xferFlag <= 1'b0;

      if (xferSet) genFlag <= 1'b1;
      else if (ctl.clrGen) genFlag <= 1'b0;

      if (ctl.enWr) irqEn <= ctl.enVal;
    end
  end

  assert_aas_on_match_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(aasFlag) |-> $past(addrDone && !isMaster && !fmtSel && addrByte == secondAddr));
  assert_master_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
    isMaster |=> !aasFlag);
  assert_start_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (startDet && !addrDone) |=> !aasFlag);
  assert_gen_with_xfer_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(xferFlag) |-> genFlag);
  assert_xfer_implies_gen_R7: assert property (@(posedge clk) disable iff (!rst_n)
    xferFlag |-> genFlag);
  assert_no_sw_set_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(genFlag) |-> $past(txEmptySet || rxFullSet));
endmodule

// File: rtl/i2c_status_flags.sv
module i2c_status_flags
  import i2cflag_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              startDet,
  input  logic              addrDone,
  input  logic [ADDR_W-1:0] addrByte,
  input  logic              txEmptySet,
  input  logic              rxFullSet,
  input  logic              isMaster,
  input  logic              fmtSel,
  input  logic [ADDR_W-1:0] secondAddr,
  input  logic              cpuRd,
  input  logic              cpuWr,
  input  logic [REG_W-1:0]  cpuWdata,
  output logic [REG_W-1:0]  cpuRdata,
  output logic              irq
);
  flagCtl_t ctl;
  logic genFlag, xferFlag, aasFlag, irqEn;

  i2cflag_ctl u_ctl (
    .clk      (clk),
    .rst_n    (rst_n),
    .cpuRd    (cpuRd),
    .cpuWr    (cpuWr),
    .cpuWdata (cpuWdata),
    .flagsNow ({aasFlag, xferFlag, genFlag}),
    .ctl      (ctl)
  );

  i2cflag_dp u_dp (
    .clk        (clk),
    .rst_n      (rst_n),
    .startDet   (startDet),
    .addrDone   (addrDone),
    .addrByte   (addrByte),
    .txEmptySet (txEmptySet),
    .rxFullSet  (rxFullSet),
    .isMaster   (isMaster),
    .fmtSel     (fmtSel),
    .secondAddr (secondAddr),
    .ctl        (ctl),
    .genFlag    (genFlag),
    .xferFlag   (xferFlag),
    .aasFlag    (aasFlag),
    .irqEn      (irqEn)
  );

  always_comb begin
    cpuRdata           = '0;
    cpuRdata[GEN_BIT]  = genFlag;
    cpuRdata[XFER_BIT] = xferFlag;
    cpuRdata[AAS_BIT]  = aasFlag;
    cpuRdata[EN_BIT]   = irqEn;
  end

  assign irq = genFlag && irqEn;

  assert_gen_fall_needs_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(genFlag) |-> $past(cpuWr && !cpuWdata[GEN_BIT]));
  assert_set_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (txEmptySet && isMaster) |=> genFlag && xferFlag);
endmodule

// File: tb/test_i2c_status_flags.sv
module test_i2c_status_flags;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic startDet = 0, addrDone = 0, txEmptySet = 0, rxFullSet = 0;
  logic isMaster = 0, fmtSel = 0, cpuRd = 0, cpuWr = 0;
  logic [6:0] addrByte = 0, secondAddr = 7'h5A;
  logic [7:0] cpuWdata = 0;
  logic [7:0] cpuRdata;
  logic irq;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  i2c_status_flags i_i2c_status_flags (
    .clk(clk), .rst_n(rst_n), .startDet(startDet), .addrDone(addrDone),
    .addrByte(addrByte), .txEmptySet(txEmptySet), .rxFullSet(rxFullSet),
    .isMaster(isMaster), .fmtSel(fmtSel), .secondAddr(secondAddr),
    .cpuRd(cpuRd), .cpuWr(cpuWr), .cpuWdata(cpuWdata),
    .cpuRdata(cpuRdata), .irq(irq)
  );

  // behavioural reference model
  bit mGen, mXfer, mAas, mEn, mFirst;
  bit [2:0] mArm;
  always @(posedge clk) begin
    bit xs, as, cg, cx, ca;
    if (!rst_n) begin
      mGen = 0; mXfer = 0; mAas = 0; mEn = 0; mFirst = 0; mArm = 0;
    end else begin
      xs = (txEmptySet || rxFullSet) && (isMaster || mAas);
      as = addrDone && mFirst && !isMaster && !fmtSel && addrByte == secondAddr;
      cg = cpuWr && mArm[0] && !cpuWdata[0];
      cx = cpuWr && mArm[1] && !cpuWdata[1];
      ca = cpuWr && mArm[2] && !cpuWdata[2];
      if (cpuWr) mArm = 0;
      else if (cpuRd) mArm = mArm | {mAas, mXfer, mGen};
      if (cpuWr) mEn = cpuWdata[7];
      if (startDet) mFirst = 1; else if (addrDone) mFirst = 0;
      if (xs) begin mGen = 1; mXfer = 1; end
      else begin
        if (cg) begin mGen = 0; mXfer = 0; end
        if (cx) mXfer = 0;
      end
      if (as) mAas = 1;
      else if (startDet || isMaster || ca) mAas = 0;
    end
  end

  task automatic check(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n) begin
      check(cpuRdata[0] == mGen,  "R6",  cpuRdata, {mEn, 4'b0, mAas, mXfer, mGen});
      check(cpuRdata[1] == mXfer, "R4",  cpuRdata, {mEn, 4'b0, mAas, mXfer, mGen});
      check(cpuRdata[2] == mAas,  "R1",  cpuRdata, {mEn, 4'b0, mAas, mXfer, mGen});
      check(cpuRdata[7] == mEn && cpuRdata[6:3] == 0, "R11", cpuRdata, {mEn, 4'b0, mAas, mXfer, mGen});
      check(irq == (mGen && mEn), "R11", {7'b0, irq}, {7'b0, mGen && mEn});
    end
  end

  task automatic cyc();
    @(posedge clk); #1;
    startDet = 0; addrDone = 0; txEmptySet = 0; rxFullSet = 0; cpuRd = 0; cpuWr = 0;
  endtask
  task automatic rd(); cpuRd = 1; cyc(); endtask
  task automatic wr(input logic [7:0] d); cpuWr = 1; cpuWdata = d; cyc(); endtask
  task automatic expect_reg(input logic [7:0] e, input string req);
    check(cpuRdata == e, req, cpuRdata, e);
  endtask

  initial begin
    fork
      begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    join_none

    repeat (3) @(posedge clk); #1;
    check(cpuRdata == 0 && irq == 0, "R8", cpuRdata, 8'h00);
    rst_n = 1;
    cyc();
    expect_reg(8'h00, "R8");

    wr(8'hFF);             expect_reg(8'h80, "R12");
    isMaster = 1; txEmptySet = 1; cyc();
    expect_reg(8'h83, "R5");
    check(irq == 1, "R11", {7'b0, irq}, 8'h01);
    wr(8'h80);             expect_reg(8'h83, "R3");
    rd(); wr(8'h81);       expect_reg(8'h81, "R3");
    rxFullSet = 1; cyc();  expect_reg(8'h83, "R6");
    rd(); wr(8'h82);       expect_reg(8'h80, "R7");
    check(irq == 0, "R11", {7'b0, irq}, 8'h00);
    txEmptySet = 1; cyc();
    rd(); wr(8'h83); wr(8'h80);  expect_reg(8'h83, "R10");
    rd(); cpuWr = 1; cpuWdata = 8'h80; txEmptySet = 1; cyc();
    expect_reg(8'h83, "R9");
    rd(); wr(8'h80);       expect_reg(8'h80, "R3");

    isMaster = 0; fmtSel = 0;
    startDet = 1; cyc();
    addrDone = 1; addrByte = 7'h5A; cyc();  expect_reg(8'h84, "R1");
    rxFullSet = 1; cyc();                   expect_reg(8'h87, "R4");
    rd(); wr(8'h80);                        expect_reg(8'h80, "R3");
    rxFullSet = 1; cyc();                   expect_reg(8'h80, "R4");
    startDet = 1; cyc();
    addrDone = 1; addrByte = 7'h11; cyc();
    addrDone = 1; addrByte = 7'h5A; cyc();  expect_reg(8'h80, "R1");
    fmtSel = 1; startDet = 1; cyc();
    addrDone = 1; addrByte = 7'h5A; cyc();  expect_reg(8'h80, "R1");
    fmtSel = 0; startDet = 1; cyc();
    addrDone = 1; cyc();                    expect_reg(8'h84, "R1");
    startDet = 1; cyc();                    expect_reg(8'h80, "R2");
    addrDone = 1; cyc();                    expect_reg(8'h84, "R1");
    isMaster = 1; cyc();                    expect_reg(8'h80, "R2");
    wr(8'h00);
    txEmptySet = 1; cyc();
    expect_reg(8'h03, "R11");
    check(irq == 0, "R11", {7'b0, irq}, 8'h00);

    for (int i = 0; i < 4000; i++) begin
      int r;
      r = $urandom_range(0, 99);
      startDet   = (r < 8);
      addrDone   = ($urandom_range(0, 99) < 12);
      addrByte   = ($urandom_range(0, 1) != 0) ? 7'h5A : 7'($urandom);
      txEmptySet = ($urandom_range(0, 99) < 10);
      rxFullSet  = ($urandom_range(0, 99) < 10);
      if ($urandom_range(0, 99) < 4) isMaster = ~isMaster;
      if ($urandom_range(0, 99) < 3) fmtSel = ~fmtSel;
      cpuRd      = ($urandom_range(0, 99) < 30);
      cpuWr      = ($urandom_range(0, 99) < 20);
      cpuWdata   = 8'($urandom);
      cyc();
    end

    repeat (2) cyc();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule